// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block gathers 32 interrupt request lines into two processor-facing outputs, one critical and one non-critical. Each request line first passes through a two-flop synchroniser. Software then chooses per source whether it is sensed by level or by edge, and which polarity counts as active. A detected event sets a pending bit that stays set until software clears it.

An enable mask decides which pending bits can reach an output. A class bit per source then steers each enabled pending source to the critical output or to the non-critical one. Software reaches every register through a small word-addressed bus with separate read and write strobes. Chaining several controllers together is left to the surrounding logic.

Top module: `irq_hub`

## Requirements
- R1: There are 32 sources. Source n sits at register bit 31-n in every per-source register, so source 0 is bit 31. The word offsets are: pending 0x0, enable 0x2, class 0x3, polarity 0x4, trigger 0x5, masked pending 0x6, vector 0x7 and vector configuration 0x8.
- R2: While reset is active, and directly after it, the following are all zero: the pending, enable, class, polarity and trigger registers, both outputs, and the read data. The synchroniser stages come out of reset high.
- R3: The enable, class, polarity and trigger registers read back the last value written to them. Read data appears in the cycle after the cycle in which rd_i is high, and it holds its value at all other times.
- R4: Writing 1 to a bit of the pending register clears that bit, and writing 0 leaves the bit unchanged. If a clear and a new event for the same source meet in one cycle, the event wins.
- R5: A trigger bit of 0 selects level sensing. With polarity 1 the active level is high, and with polarity 0 it is low. The pending bit stays set while the input is at its active level, even when software clears it.
- R6: A trigger bit of 1 selects edge sensing. Polarity 1 selects the rising edge and polarity 0 selects the falling edge. The opposite transition does not set the pending bit.
- R7: The masked pending register reads as the pending register ANDed with the enable register.
- R8: A class bit of 1 routes the source to crit_irq_o, and a class bit of 0 routes it to norm_irq_o. Each output is the OR of the masked pending bits in its class, registered for one cycle.
- R9: Reads of the vector registers and of unused offsets return zero. Writes to these offsets, and writes to the masked pending register, change nothing.
- R10: A change on a request line in level mode reaches the pending register on the third rising clock edge and reaches an output on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 32 | Request lines, bit n is source n |
| addr_i | input | 4 | Register word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| crit_irq_o | output | 1 | Critical interrupt request |
| norm_irq_o | output | 1 | Non-critical interrupt request |

## Verification
The assertions assume that wr_i and rd_i are never high in the same cycle. They also assume that addr_i and wdata_i are stable whenever a strobe is high. The stimulus drives the strobes one at a time, only on falling clock edges, and always holds each strobe for exactly one cycle. Request lines also change only on falling edges. After each change they are held for at least six cycles, so that the synchroniser and the edge detector settle before the bench clears the pending bits or reads them.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NSRC   = 32;
  localparam int ADDR_W = 4;

  localparam int OFF_PEND = 'h0;
  localparam int OFF_EN   = 'h2;
  localparam int OFF_CLS  = 'h3;
  localparam int OFF_POL  = 'h4;
  localparam int OFF_TRG  = 'h5;
  localparam int OFF_MSK  = 'h6;
  localparam int OFF_VEC  = 'h7;
  localparam int OFF_VCFG = 'h8;
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int         W       = 32,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_hub_sense.sv
module irq_hub_sense #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q, pend_q, hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_comb begin
      if (trig_i[i]) hit[i] = pol_i[i] ? (lvl_i[i] & ~prev_q[i]) : (~lvl_i[i] & prev_q[i]);
      else           hit[i] = (lvl_i[i] == pol_i[i]);
    end
  end

  // new event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= hit | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_hub_route.sv
module irq_hub_route #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] cls_i,
  output logic [N-1:0] masked_o,
  output logic         crit_o,
  output logic         norm_o
);
  assign masked_o = pend_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_o <= 1'b0;
      norm_o <= 1'b0;
    end else begin
      crit_o <= |(masked_o & cls_i);
      norm_o <= |(masked_o & ~cls_i);
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_src_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [N-1:0]  wdata_i,
  input  logic          rd_i,
  output logic [N-1:0]  rdata_o,
  output logic          crit_irq_o,
  output logic          norm_irq_o
);
  // registers held in bus order: bit N-1-n belongs to source n
  logic [N-1:0] en_q, cls_q, pol_q, trg_q;
  logic [N-1:0] pend_bus, msk_bus, clr_bus;
  logic [N-1:0] en_s, cls_s, pol_s, trg_s, clr_s, pend_s, msk_s, lvl_s;
  logic [N-1:0] rd_mux;

  logic sel_pend, sel_en, sel_cls, sel_pol, sel_trg, sel_msk;
  assign sel_pend = (addr_i == AW'(OFF_PEND));
  assign sel_en   = (addr_i == AW'(OFF_EN));
  assign sel_cls  = (addr_i == AW'(OFF_CLS));
  assign sel_pol  = (addr_i == AW'(OFF_POL));
  assign sel_trg  = (addr_i == AW'(OFF_TRG));
  assign sel_msk  = (addr_i == AW'(OFF_MSK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cls_q <= '0;
      pol_q <= '0;
      trg_q <= '0;
    end else if (wr_i) begin
      if (sel_en)  en_q  <= wdata_i;
      if (sel_cls) cls_q <= wdata_i;
      if (sel_pol) pol_q <= wdata_i;
      if (sel_trg) trg_q <= wdata_i;
    end
  end

  assign clr_bus = (wr_i && sel_pend) ? wdata_i : '0;

  for (genvar i = 0; i < N; i++) begin : g_flip
    assign en_s[i]            = en_q[N-1-i];
    assign cls_s[i]           = cls_q[N-1-i];
    assign pol_s[i]           = pol_q[N-1-i];
    assign trg_s[i]           = trg_q[N-1-i];
    assign clr_s[i]           = clr_bus[N-1-i];
    assign pend_bus[N-1-i]    = pend_s[i];
    assign msk_bus[N-1-i]     = msk_s[i];
  end

  irq_hub_sync #(.W(N), .RST_VAL({N{1'b1}})) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_src_i),
    .q_o    (lvl_s)
  );

  irq_hub_sense #(.N(N)) u_sense (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_s),
    .trig_i (trg_s),
    .pol_i  (pol_s),
    .clr_i  (clr_s),
    .pend_o (pend_s)
  );

  irq_hub_route #(.N(N)) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend_s),
    .en_i     (en_s),
    .cls_i    (cls_s),
    .masked_o (msk_s),
    .crit_o   (crit_irq_o),
    .norm_o   (norm_irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_pend) rd_mux = pend_bus;
    if (sel_en)   rd_mux = en_q;
    if (sel_cls)  rd_mux = cls_q;
    if (sel_pol)  rd_mux = pol_q;
    if (sel_trg)  rd_mux = trg_q;
    if (sel_msk)  rd_mux = msk_bus;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          rd_i,
  input logic [AW-1:0] addr_i,
  input logic [N-1:0]  wdata_i,
  input logic [N-1:0]  rdata_o,
  input logic          crit_irq_o,
  input logic          norm_irq_o,
  input logic [N-1:0]  pend_i,
  input logic [N-1:0]  en_i,
  input logic [N-1:0]  cls_i
);
  AST_PEND_DROP_ONLY_BY_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_i) & ~pend_i & ~($past(wr_i && addr_i == AW'(0)) ? $past(wdata_i) : '0)) == '0)); // R4

  AST_CFG_HOLD_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> ($stable(en_i) && $stable(cls_i))); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o)); // R3

  AST_CRIT_FOLLOWS_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_irq_o == $past(|(pend_i & en_i & cls_i))); // R8

  AST_NORM_FOLLOWS_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_irq_o == $past(|(pend_i & en_i & ~cls_i))); // R8

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && !(addr_i inside {AW'(0), AW'(2), AW'(3), AW'(4), AW'(5), AW'(6)}))
    |-> (rdata_o == '0)); // R9
endmodule

bind irq_hub irq_hub_chk #(.N(N), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .crit_irq_o (crit_irq_o),
  .norm_irq_o (norm_irq_o),
  .pend_i     (pend_bus),
  .en_i       (en_q),
  .cls_i      (cls_q)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_src_i = '1;
  logic [3:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic        crit_irq_o, norm_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_hub u_irq_hub (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_src_i  (irq_src_i),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .rd_i       (rd_i),
    .rdata_o    (rdata_o),
    .crit_irq_o (crit_irq_o),
    .norm_irq_o (norm_irq_o)
  );

  typedef struct packed {
    logic [31:0] trg, pol, en, cls, src_a, src_b, pend, msk;
    logic        crit, norm;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // level high, source 31, latched after the line drops
    '{32'h0, 32'h1, 32'h1, 32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1, 32'h1, 1'b0, 1'b1},
    // level low, source 0, critical class
    '{32'h0, 32'h0, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0},
    // rising edge, source 4
    '{32'h0800_0000, 32'h0800_0000, 32'h0800_0000, 32'h0, 32'hFFFF_FFEF, 32'hFFFF_FFFF, 32'h0800_0000, 32'h0800_0000, 1'b0, 1'b1},
    // rising-edge source sees only a falling edge
    '{32'h0800_0000, 32'h0800_0000, 32'h0800_0000, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFEF, 32'h0, 32'h0, 1'b0, 1'b0},
    // falling edge, source 4, critical class
    '{32'h0800_0000, 32'h0, 32'h0800_0000, 32'h0800_0000, 32'hFFFF_FFFF, 32'hFFFF_FFEF, 32'h0800_0000, 32'h0800_0000, 1'b1, 1'b0},
    // pending but masked
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h8000_0000, 32'h0, 1'b0, 1'b0},
    // two sources, one in each class
    '{32'h0, 32'h1, 32'h8000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFE, 32'h8000_0001, 32'h8000_0001, 1'b1, 1'b1},
    // level-high source never active
    '{32'h0, 32'h1, 32'h1, 32'h1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    chk("R2 crit during reset", {31'b0, crit_irq_o}, 32'h0);
    chk("R2 rdata during reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    idle(4);

    // R2: reset values
    rd(4'h0, v); chk("R2 pending", v, 32'h0);
    rd(4'h2, v); chk("R2 enable", v, 32'h0);
    rd(4'h3, v); chk("R2 class", v, 32'h0);
    rd(4'h4, v); chk("R2 polarity", v, 32'h0);
    rd(4'h5, v); chk("R2 trigger", v, 32'h0);
    rd(4'h6, v); chk("R2 masked", v, 32'h0);
    chk("R2 outputs", {30'b0, crit_irq_o, norm_irq_o}, 32'h0);

    // R3: readback
    wr(4'h2, 32'hA5A5_0F0F); wr(4'h3, 32'h0F0F_A5A5);
    wr(4'h4, 32'h1234_5678); wr(4'h5, 32'h8765_4321);
    rd(4'h2, v); chk("R3 enable readback", v, 32'hA5A5_0F0F);
    rd(4'h3, v); chk("R3 class readback", v, 32'h0F0F_A5A5);
    rd(4'h4, v); chk("R3 polarity readback", v, 32'h1234_5678);
    rd(4'h5, v); chk("R3 trigger readback", v, 32'h8765_4321);
    idle(2);
    chk("R3 rdata holds without rd", rdata_o, 32'h8765_4321);
    wr(4'h2, 32'h0); wr(4'h3, 32'h0); wr(4'h4, 32'h0); wr(4'h5, 32'h0);
    idle(6);
    wr(4'h0, 32'hFFFF_FFFF);
    idle(3);

    // R9: ignored offsets
    wr(4'h6, 32'hFFFF_FFFF); wr(4'h7, 32'hFFFF_FFFF); wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h1, 32'hFFFF_FFFF); wr(4'hF, 32'hFFFF_FFFF);
    rd(4'h7, v); chk("R9 vector reads zero", v, 32'h0);
    rd(4'h8, v); chk("R9 vector cfg reads zero", v, 32'h0);
    rd(4'h1, v); chk("R9 unused 0x1 reads zero", v, 32'h0);
    rd(4'hF, v); chk("R9 unused 0xF reads zero", v, 32'h0);
    rd(4'h6, v); chk("R9 masked write ignored", v, 32'h0);
    rd(4'h2, v); chk("R9 enable untouched", v, 32'h0);
    rd(4'h5, v); chk("R9 trigger untouched", v, 32'h0);
    rd(4'h0, v); chk("R9 pending untouched", v, 32'h0);

    // R1 R5 R6 R7 R8: vector table
    for (int k = 0; k < NV; k++) begin
      wr(4'h2, VECS[k].en); wr(4'h3, VECS[k].cls);
      wr(4'h4, VECS[k].pol); wr(4'h5, VECS[k].trg);
      irq_src_i = VECS[k].src_a;
      idle(6);
      wr(4'h0, 32'hFFFF_FFFF);
      idle(3);
      irq_src_i = VECS[k].src_b;
      idle(6);
      rd(4'h0, v); chk($sformatf("R1 R5 R6 vec%0d pending", k), v, VECS[k].pend);
      rd(4'h6, v); chk($sformatf("R7 vec%0d masked", k), v, VECS[k].msk);
      chk($sformatf("R8 vec%0d crit", k), {31'b0, crit_irq_o}, {31'b0, VECS[k].crit});
      chk($sformatf("R8 vec%0d norm", k), {31'b0, norm_irq_o}, {31'b0, VECS[k].norm});
    end

    // R4: write-one-to-clear on edge-sensed sources 0 and 1
    wr(4'h2, 32'h0); wr(4'h3, 32'h0); wr(4'h4, 32'h0); wr(4'h5, 32'hC000_0000);
    irq_src_i = 32'hFFFF_FFFF;
    idle(6);
    wr(4'h0, 32'hFFFF_FFFF);
    idle(2);
    irq_src_i = 32'hFFFF_FFFC;
    idle(6);
    rd(4'h0, v); chk("R4 two falling edges pending", v, 32'hC000_0000);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R4 zero write keeps bits", v, 32'hC000_0000);
    wr(4'h0, 32'h4000_0000);
    rd(4'h0, v); chk("R4 one bit cleared", v, 32'h8000_0000);

    // R10: input-to-output latency, source 31 level high
    wr(4'h5, 32'h0); wr(4'h4, 32'h1); wr(4'h2, 32'h1);
    irq_src_i = 32'h7FFF_FFFC;
    idle(6);
    wr(4'h0, 32'hFFFF_FFFF);
    idle(3);
    chk("R10 output idle before change", {31'b0, norm_irq_o}, 32'h0);
    irq_src_i = 32'hFFFF_FFFC;
    idle(3);
    chk("R10 output low after three edges", {31'b0, norm_irq_o}, 32'h0);
    idle(1);
    chk("R10 output high after four edges", {31'b0, norm_irq_o}, 32'h1);

    // R5 R4: active level beats clear
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R5 level sources stay pending", v, 32'hC000_0001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule